// File: doc/BRIEF.md
# I2C register access slave

This block is an I2C target that gives a host access to a register file over a two-wire bus. A write transfer starts with the device address byte. Two pointer bytes follow, high byte first, and then the register value. A read uses the same address-plus-pointer transfer to load the pointer. A repeated START follows, then the device address with the read bit set, and the target streams the register back. Every byte travels most significant bit first.

The register file sits outside the block. The block drives a 16-bit register address and receives a 2-bit width code for that address from an external lookup. The width decides how many data bytes a transfer carries (1, 2 or 4). Writes leave the block as a single strobe with the assembled value and its byte count. Reads go out as a one-cycle request and come back on a data bus. SCL and SDA are sampled by the much faster system clock. SDA is driven open-drain through an output enable.

Top module: `i2c_regport`

## Requirements
- R1: After reset, sda_oe, reg_wstb and reg_rreq are 0 and reg_addr is 0x0000.
- R2: An address byte whose upper seven bits are 0111000 (0x70 write, 0x71 read) is acknowledged. Any other address byte is not acknowledged. The rest of that transfer, until the next START, is then ignored: no ACK, no strobe, no read request, and the pointer is unchanged.
- R3: After 0x70, the next two bytes are acknowledged and load reg_addr, first byte into bits 15:8 and second into bits 7:0.
- R4: The width code maps 00 to 1 byte, 01 to 2 bytes, and 10 or 11 to 4 bytes. Data bytes are acknowledged. When that many have arrived (first byte most significant), reg_wstb pulses once with reg_wdata right-justified and zero above, reg_wbytes set to the count, and reg_addr set to the pointer.
- R5: A write ended by STOP or START before all bytes have arrived produces no strobe.
- R6: A data byte after the committed value is not acknowledged and causes no second strobe.
- R7: A 0x71 address byte produces exactly one reg_rreq pulse. The block takes reg_rdata and reg_width in the following cycle and returns the low N bytes of reg_rdata, most significant first.
- R8: The block sends the next byte only after a master ACK and while bytes remain. After a master NACK, or after the last byte, it releases SDA, so further clocks read 0xFF.
- R9: A START at any point restarts address reception. A STOP returns to idle. Both leave SDA released.
- R10: sda_oe changes only while SCL is low. START and STOP are SDA edges seen while SCL is high.
- R11: reg_wstb and reg_rreq last one system clock each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 16 | Register pointer |
| reg_wdata | output | 32 | Write value, right-justified |
| reg_wstb | output | 1 | One-cycle write commit |
| reg_wbytes | output | 3 | Bytes in the committed write (1, 2 or 4) |
| reg_rreq | output | 1 | One-cycle read request for reg_addr |
| reg_rdata | input | 32 | Read value, valid the cycle after reg_rreq |
| reg_width | input | 2 | Width code of the register at reg_addr |

## Verification
Each SCL edge reaches the engine three system clocks after the wire changes: two synchroniser stages and one event register. ACK and read bits therefore appear on sda_oe a few cycles into the SCL low phase. The bench samples SDA only in the middle of the following high phase, many cycles later. The write strobe and read request are counted by an edge monitor, and their counts and values are checked only after STOP plus a margin, so the exact cycle never matters. A separate monitor flags any change of sda_oe while SCL is high.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int unsigned PTR_W     = 16;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MAX_BYTES = DATA_W / 8;
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int unsigned IDX_W     = $clog2(MAX_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR_HI, ST_PTR_LO, ST_WDATA, ST_RDATA, ST_IGNORE
  } xfer_state_t;

  // width code -> byte count
  function automatic logic [CNT_W-1:0] width_to_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(2);
      default: return CNT_W'(4);
    endcase
  endfunction

  // byte idx (0 = first sent) of an nbytes-wide value, MS byte first
  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] word,
                                           input logic [CNT_W-1:0] nbytes,
                                           input logic [IDX_W-1:0] idx);
    logic [CNT_W-1:0]  lane;
    logic [DATA_W-1:0] shifted;
    lane    = nbytes - CNT_W'(1) - CNT_W'(idx);
    shifted = word >> {lane, 3'b000};
    return shifted[7:0];
  endfunction
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign scl_rise   = scl_s & ~scl_prev;
  assign scl_fall   = ~scl_s & scl_prev;
  assign start_seen = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_seen  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_bit_ctr.sv
module i2c_bit_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       rx_en,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  output logic [3:0] bit_cnt,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       ack_end,
  output logic       data_fall,
  output logic       master_ack
);
  // bit_cnt counts SCL rises: 1..8 data, 9 acknowledge slot
  assign byte_done = run & scl_fall & (bit_cnt == 4'd8);
  assign ack_end   = run & scl_fall & (bit_cnt == 4'd9);
  assign data_fall = run & scl_fall & (bit_cnt >= 4'd1) & (bit_cnt <= 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_byte    <= '0;
      master_ack <= 1'b0;
    end else if (restart || !run) begin
      bit_cnt <= '0;
    end else begin
      if (scl_rise && bit_cnt < 4'd9) bit_cnt <= bit_cnt + 4'd1;
      if (scl_rise && bit_cnt < 4'd8 && rx_en) rx_byte <= {rx_byte[6:0], sda_s};
      if (scl_rise && bit_cnt == 4'd8) master_ack <= ~sda_s;
      if (ack_end) bit_cnt <= '0;
    end
  end
endmodule

// File: rtl/i2c_wr_collect.sv
module i2c_wr_collect
  import i2c_regport_pkg::*;
#(
  parameter int unsigned BYTES = MAX_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 push,
  input  logic [7:0]           din,
  input  logic [CNT_W-1:0]     need,
  output logic                 full,
  output logic                 wstb,
  output logic [8*BYTES-1:0]   wdata,
  output logic [CNT_W-1:0]     wbytes
);
  localparam int unsigned ACC_W = 8 * BYTES;

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc_next;
  logic [CNT_W-1:0] cnt_next;

  assign acc_next = {acc[ACC_W-9:0], din};
  assign cnt_next = cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      full   <= 1'b0;
      wstb   <= 1'b0;
      wdata  <= '0;
      wbytes <= '0;
    end else begin
      wstb <= 1'b0;
      if (clear) begin
        acc  <= '0;
        cnt  <= '0;
        full <= 1'b0;
      end else if (push && !full) begin
        acc <= acc_next;
        cnt <= cnt_next;
        if (cnt_next == need) begin
          full   <= 1'b1;
          wstb   <= 1'b1;
          wdata  <= acc_next;
          wbytes <= need;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b0111000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wstb,
  output logic [CNT_W-1:0]  reg_wbytes,
  output logic              reg_rreq,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        reg_width
);
  // named internal events
  logic scl_s, sda_s, scl_rise, scl_fall, evt_start, evt_stop;
  logic [3:0] bit_cnt;
  logic [7:0] rx_byte;
  logic byte_done, ack_end, data_fall, master_ack;
  logic run, rx_en, st_addr, addr_hit;
  logic wr_clear, wr_push, wr_full;

  xfer_state_t state, nxt;
  logic [7:0]        ptr_hi;
  logic [DATA_W-1:0] rd_word;
  logic [CNT_W-1:0]  rd_n;
  logic [IDX_W-1:0]  rd_idx;
  logic              rreq_d;
  logic [7:0]        tx_first, tx_cur, tx_next;
  logic              more_bytes;

  i2c_line_cond #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_seen(evt_start), .stop_seen(evt_stop)
  );

  assign run   = (state == ST_ADDR) || (state == ST_PTR_HI) || (state == ST_PTR_LO)
              || (state == ST_WDATA) || (state == ST_RDATA);
  assign rx_en = (state != ST_RDATA);

  i2c_bit_ctr u_bits (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(evt_start), .rx_en(rx_en),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bit_cnt(bit_cnt), .rx_byte(rx_byte), .byte_done(byte_done),
    .ack_end(ack_end), .data_fall(data_fall), .master_ack(master_ack)
  );

  assign st_addr  = (state == ST_ADDR);
  assign addr_hit = (rx_byte[7:1] == DEV_ADDR);
  assign wr_clear = evt_start || (byte_done && state == ST_PTR_LO);
  assign wr_push  = byte_done && (state == ST_WDATA) && !wr_full;

  i2c_wr_collect #(.BYTES(MAX_BYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .clear(wr_clear), .push(wr_push), .din(rx_byte),
    .need(width_to_bytes(reg_width)), .full(wr_full), .wstb(reg_wstb),
    .wdata(reg_wdata), .wbytes(reg_wbytes)
  );

  assign tx_first   = pick_byte(rd_word, rd_n, '0);
  assign tx_cur     = pick_byte(rd_word, rd_n, rd_idx);
  assign tx_next    = pick_byte(rd_word, rd_n, rd_idx + IDX_W'(1));
  assign more_bytes = (CNT_W'(rd_idx) + CNT_W'(1)) < rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rreq_d <= 1'b0;
    else        rreq_d <= reg_rreq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      sda_oe   <= 1'b0;
      reg_addr <= '0;
      ptr_hi   <= '0;
      rd_word  <= '0;
      rd_n     <= CNT_W'(1);
      rd_idx   <= '0;
      reg_rreq <= 1'b0;
    end else begin
      reg_rreq <= 1'b0;
      if (evt_start) begin
        state  <= ST_ADDR;
        sda_oe <= 1'b0;
      end else if (evt_stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (rreq_d) begin
          rd_word <= reg_rdata;
          rd_n    <= width_to_bytes(reg_width);
        end
        if (byte_done) begin
          case (state)
            ST_ADDR: begin
              if (addr_hit) begin
                sda_oe   <= 1'b1;
                nxt      <= rx_byte[0] ? ST_RDATA : ST_PTR_HI;
                reg_rreq <= rx_byte[0];
              end else begin
                sda_oe <= 1'b0;
                nxt    <= ST_IGNORE;
              end
            end
            ST_PTR_HI: begin
              sda_oe <= 1'b1;
              ptr_hi <= rx_byte;
              nxt    <= ST_PTR_LO;
            end
            ST_PTR_LO: begin
              sda_oe   <= 1'b1;
              reg_addr <= {ptr_hi, rx_byte};
              nxt      <= ST_WDATA;
            end
            ST_WDATA: begin
              sda_oe <= !wr_full;
              nxt    <= wr_full ? ST_IGNORE : ST_WDATA;
            end
            ST_RDATA: sda_oe <= 1'b0;
            default:  sda_oe <= 1'b0;
          endcase
        end
        if (data_fall && state == ST_RDATA) sda_oe <= ~tx_cur[3'd7 - bit_cnt[2:0]];
        if (ack_end) begin
          if (state == ST_RDATA) begin
            if (master_ack && more_bytes) begin
              rd_idx <= rd_idx + IDX_W'(1);
              sda_oe <= ~tx_next[7];
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_IGNORE;
            end
          end else begin
            state <= nxt;
            if (nxt == ST_RDATA) begin
              rd_idx <= '0;
              sda_oe <= ~tx_first[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       byte_done,
  input logic       st_addr,
  input logic       addr_hit,
  input logic       reg_wstb,
  input logic [2:0] reg_wbytes,
  input logic       reg_rreq
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> !sda_oe); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !sda_oe); // R9
  AST_MISMATCH_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st_addr && !addr_hit) |=> !sda_oe); // R2
  AST_MATCH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st_addr && addr_hit) |=> sda_oe); // R2
  AST_WSTB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wstb |=> !reg_wstb); // R11
  AST_WBYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wstb |-> ($countones(reg_wbytes) == 1 && reg_wbytes <= 3'd4)); // R4
  AST_RREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rreq |=> !reg_rreq); // R11
  AST_RREQ_AFTER_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rreq |-> $past(byte_done && st_addr && addr_hit)); // R7
endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .evt_start(evt_start), .evt_stop(evt_stop), .byte_done(byte_done),
  .st_addr(st_addr), .addr_hit(addr_hit), .reg_wstb(reg_wstb),
  .reg_wbytes(reg_wbytes), .reg_rreq(reg_rreq)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        mdrv = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_wstb;
  logic [2:0]  reg_wbytes;
  logic        reg_rreq;
  logic [31:0] reg_rdata;
  logic [1:0]  reg_width;

  int tests = 0;
  int fails = 0;
  int wcount = 0;
  int rcount = 0;
  int oe_viol = 0;
  logic [31:0] w_data_q = '0;
  logic [2:0]  w_bytes_q = '0;
  logic [15:0] w_addr_q = '0;
  logic        oe_prev = 1'b0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = mdrv & ~sda_oe;

  function automatic logic [31:0] model(input logic [15:0] a);
    return {a ^ 16'hA55A, a ^ 16'h3C96};
  endfunction
  function automatic int nbytes_of(input logic [15:0] a);
    return (a[1:0] == 2'b00) ? 1 : (a[1:0] == 2'b01) ? 2 : 4;
  endfunction
  function automatic logic [31:0] mask_of(input int n);
    return (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign reg_width = reg_addr[1:0];
  assign reg_rdata = model(reg_addr);

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wstb(reg_wstb),
    .reg_wbytes(reg_wbytes), .reg_rreq(reg_rreq), .reg_rdata(reg_rdata),
    .reg_width(reg_width)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_wstb) begin
        wcount    = wcount + 1;
        w_data_q  = reg_wdata;
        w_bytes_q = reg_wbytes;
        w_addr_q  = reg_addr;
      end
      if (reg_rreq) rcount = rcount + 1;
      if (sda_oe !== oe_prev && scl === 1'b1) oe_viol = oe_viol + 1;
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    mdrv = 1'b1; tick(Q); scl = 1'b1; tick(Q); mdrv = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; mdrv = 1'b0; tick(Q); scl = 1'b1; tick(Q); mdrv = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mdrv = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    mdrv = 1'b1; tick(Q); scl = 1'b1; tick(Q); acked = ~sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    mdrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    end
    mdrv = ~give_ack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q); mdrv = 1'b1;
  endtask

  task automatic set_ptr(input logic [15:0] a, output logic ok);
    logic k0, k1, k2;
    bus_start();
    wr_byte(8'h70, k0); wr_byte(a[15:8], k1); wr_byte(a[7:0], k2);
    ok = k0 & k1 & k2;
  endtask

  // {pointer, write value}; width follows pointer bits 1:0
  localparam logic [47:0] VEC [6] = '{
    {16'h0000, 32'h0000_00A7},
    {16'h1231, 32'h0000_BEEF},
    {16'h4002, 32'hDEAD_BEEF},
    {16'hFFFF, 32'h1234_5678},
    {16'h0104, 32'h0000_005C},
    {16'h80FD, 32'h0000_8001}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R9: actual hung expected transfer completion (watchdog)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ok, ak;
    logic [7:0] b;
    int wc, rc;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 reg_wstb", {31'd0, reg_wstb}, 32'd0);
    chk("R1 reg_rreq", {31'd0, reg_rreq}, 32'd0);
    chk("R1 reg_addr", {16'd0, reg_addr}, 32'd0);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] a;
      logic [31:0] val, got, exp;
      logic allak;
      int n;
      a = VEC[v][47:32]; val = VEC[v][31:0]; n = nbytes_of(a);
      wc = wcount; rc = rcount;
      set_ptr(a, ok);
      allak = ok;
      for (int k = n - 1; k >= 0; k--) begin
        wr_byte(val[8*k +: 8], ak);
        allak = allak & ak;
      end
      bus_stop(); tick(4);
      chk("R3 R4 all bytes acked", {31'd0, allak}, 32'd1);
      chk("R4 one strobe", wcount - wc, 1);
      chk("R4 wdata", w_data_q, val & mask_of(n));
      chk("R4 wbytes", {29'd0, w_bytes_q}, n);
      chk("R3 pointer", {16'd0, w_addr_q}, {16'd0, a});
      set_ptr(a, ok);
      bus_start();
      wr_byte(8'h71, ak);
      chk("R7 read address ack", {31'd0, ak}, 32'd1);
      got = '0;
      for (int k = 0; k < n; k++) begin
        rd_byte(k != n - 1, b);
        got = {got[23:0], b};
      end
      bus_stop(); tick(4);
      exp = model(a) & mask_of(n);
      chk("R7 read value", got, exp);
      chk("R7 R11 one read request", rcount - rc, 1);
      chk("R9 released after stop", {31'd0, sda_oe}, 32'd0);
    end

    // R2: foreign address ignored
    wc = wcount; rc = rcount;
    bus_start();
    wr_byte(8'h72, ak);
    chk("R2 foreign address nack", {31'd0, ak}, 32'd0);
    wr_byte(8'h12, ak);
    chk("R2 following byte nack", {31'd0, ak}, 32'd0);
    wr_byte(8'h34, ak);
    bus_stop(); tick(4);
    chk("R2 no strobe", wcount - wc, 0);
    chk("R2 no read request", rcount - rc, 0);
    chk("R2 pointer unchanged", {16'd0, reg_addr}, {16'd0, 16'h80FD});

    // R5: partial write ended by STOP
    wc = wcount;
    set_ptr(16'h4002, ok);
    wr_byte(8'hAA, ak); wr_byte(8'hBB, ak);
    bus_stop(); tick(4);
    chk("R5 no strobe after stop", wcount - wc, 0);

    // R5 R9: partial write cut by repeated START, then a fresh write
    wc = wcount;
    set_ptr(16'h4002, ok);
    wr_byte(8'hAB, ak);
    set_ptr(16'h0000, ok);
    chk("R9 restart acked", {31'd0, ok}, 32'd1);
    wr_byte(8'h3C, ak);
    bus_stop(); tick(4);
    chk("R5 R9 single strobe", wcount - wc, 1);
    chk("R9 restart data", w_data_q, 32'h3C);
    chk("R9 restart pointer", {16'd0, w_addr_q}, 32'd0);

    // R6: extra byte after commit
    wc = wcount;
    set_ptr(16'h0000, ok);
    wr_byte(8'h11, ak);
    wr_byte(8'h22, ak);
    chk("R6 excess byte nack", {31'd0, ak}, 32'd0);
    bus_stop(); tick(4);
    chk("R6 one strobe", wcount - wc, 1);
    chk("R6 committed value", w_data_q, 32'h11);

    // R8: early master NACK releases SDA
    set_ptr(16'h4002, ok);
    bus_start();
    wr_byte(8'h71, ak);
    rd_byte(1'b0, b);
    chk("R8 first byte", {24'd0, b}, {24'd0, model(16'h4002)[31:24]});
    rd_byte(1'b0, b);
    chk("R8 released after nack", {24'd0, b}, 32'hFF);
    bus_stop(); tick(4);

    // R8: ACK on last byte still ends the read
    set_ptr(16'h0104, ok);
    bus_start();
    wr_byte(8'h71, ak);
    rd_byte(1'b1, b);
    chk("R8 single byte", {24'd0, b}, {24'd0, model(16'h0104)[7:0]});
    rd_byte(1'b0, b);
    chk("R8 released after last", {24'd0, b}, 32'hFF);
    bus_stop(); tick(4);

    chk("R10 sda_oe steady while SCL high", oe_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule